// File: doc/BRIEF.md
# Segmented Pairwise Vector Adder

This block is a vector datapath stage with two source vectors of a fixed compile-time width, `VEC_W`, and one destination vector. Each vector is cut into 128-bit segments. For every segment index the block joins the two matching source segments into one 256-bit value, with the first source in the low half and the second source in the high half. It then sums neighbouring element pairs of that joined value. The sums fill the matching destination segment. As a result, the lower half of each output segment depends only on the first source and the upper half only on the second.

A 2-bit code selects the element width at run time. The block accepts one operation per cycle through a valid/ready handshake and holds the result in a register with a valid flag. The output stage stalls when the consumer is not ready. Timing is fixed: a result always appears one cycle after acceptance, whatever the operand values.

Top module: `seg_pair_adder`

## Requirements
- R1: The element width is 8 shifted left by `size_code`, so codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements.
- R2: For segment s at element width W, output element e for e below 64/W is `src_a` segment s element 2e plus element 2e+1. This fills bits [63:0] of the segment.
- R3: For segment s, output element e for e from 64/W up to 128/W-1 is the sum of `src_b` segment s elements 2e-128/W and 2e-128/W+1. This fills bits [127:64] of the segment.
- R4: Every sum wraps modulo 2^W, and no carry passes from one element into its neighbour.
- R5: Every bit of `out_data` is written on every accepted operation, with no masking.
- R6: `in_ready` is high when `out_valid` is low or `out_ready` is high. An operation is accepted when `in_valid` and `in_ready` are both high. `out_valid` is high in the cycle after acceptance, independent of operand values.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values and no new operation is accepted.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero.
- R9: `VEC_W` must be a multiple of 128. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| size_code | input | 2 | Element width select (8 << code bits) |
| src_a | input | VEC_W | First source vector |
| src_b | input | VEC_W | Second source vector |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | VEC_W | Destination vector |

## Verification
The bench builds the block with the default `VEC_W` of 512, which gives four segments. With four segments, a result landing in the wrong segment index is visible, and so is a swap of which source feeds which half of a segment. All four size codes run with all-ones operands to drive the wrap at every element width. Additional patterns zero one source while the other carries random data, which shows the two halves of each segment fed from separate sources. A repeating `out_ready` pattern produces stalls and back-to-back transfers.

// File: rtl/seg_pair_pkg.sv
package seg_pair_pkg;

  localparam int SEG_W  = 128;
  localparam int N_SIZE = 4;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esize_e;

  // element width in bits for a size code
  function automatic int unsigned elem_bits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction

  // wrap-around sum of two fields held in 64-bit containers
  function automatic logic [63:0] wrap_sum(input logic [63:0] x,
                                           input logic [63:0] y,
                                           input int unsigned w);
    logic [63:0] mask;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (x + y) & mask;
  endfunction

endpackage

// File: rtl/seg_pair_lane.sv
module seg_pair_lane
  import seg_pair_pkg::*;
(
  input  logic [SEG_W-1:0] lo_seg,
  input  logic [SEG_W-1:0] hi_seg,
  input  logic [1:0]       size_code,
  output logic [SEG_W-1:0] sum_seg
);

  localparam int JOIN_W = 2 * SEG_W;

  logic [JOIN_W-1:0] joined;
  logic [SEG_W-1:0]  cand [N_SIZE];

  assign joined = {hi_seg, lo_seg};

  for (genvar g = 0; g < N_SIZE; g++) begin : g_width
    localparam int EW = 8 << g;
    localparam int NE = SEG_W / EW;
    for (genvar e = 0; e < NE; e++) begin : g_elem
      logic [63:0] ev_part;
      logic [63:0] od_part;
      logic [63:0] s;
      assign ev_part = 64'(joined[(2*e)*EW +: EW]);
      assign od_part = 64'(joined[(2*e+1)*EW +: EW]);
      assign s       = wrap_sum(ev_part, od_part, EW);
      assign cand[g][e*EW +: EW] = s[EW-1:0];
    end
  end

  always_comb begin
    unique case (esize_e'(size_code))
      ESZ_8:   sum_seg = cand[0];
      ESZ_16:  sum_seg = cand[1];
      ESZ_32:  sum_seg = cand[2];
      default: sum_seg = cand[3];
    endcase
  end

  // R2 R3: at 64-bit width the two halves come from separate sources
  always_comb begin
    if (!$isunknown({lo_seg, hi_seg, size_code}) && size_code == 2'd3) begin
      // R2
      lane_lo_half_chk: assert (sum_seg[63:0] == lo_seg[63:0] + lo_seg[127:64]);
      // R3
      lane_hi_half_chk: assert (sum_seg[127:64] == hi_seg[63:0] + hi_seg[127:64]);
    end
  end

endmodule

// File: rtl/seg_pair_out_reg.sv
module seg_pair_out_reg #(
  parameter int W = 512
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] nxt_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic accept;
  logic hold;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign hold     = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= nxt_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R5
  full_capture_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_data == $past(nxt_data)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (out_valid && $stable(out_data)));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> !accept);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

endmodule

// File: rtl/seg_pair_adder.sv
module seg_pair_adder
  import seg_pair_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       size_code,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);

  localparam int N_SEG = VEC_W / SEG_W;

  // R9
  if ((VEC_W % SEG_W) != 0 || VEC_W < SEG_W) begin : g_bad_width
    $error("seg_pair_adder: VEC_W must be a positive multiple of 128");
  end

  logic [VEC_W-1:0] sum_vec;

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    seg_pair_lane u_lane (
      .lo_seg   (src_a[s*SEG_W +: SEG_W]),
      .hi_seg   (src_b[s*SEG_W +: SEG_W]),
      .size_code(size_code),
      .sum_seg  (sum_vec[s*SEG_W +: SEG_W])
    );
  end

  seg_pair_out_reg #(.W(VEC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .nxt_data (sum_vec),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

endmodule

// File: tb/seg_pair_adder_tb_top.sv
module seg_pair_adder_tb_top;

  localparam int VW = 512;
  localparam int NS = VW / 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [1:0]    size_code;
  logic [VW-1:0] src_a;
  logic [VW-1:0] src_b;
  logic          out_valid;
  logic          out_ready;
  logic [VW-1:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [VW-1:0] exp_q  [$];
  int            tag_q  [$];

  always #4 clk = ~clk;   // 125 MHz

  seg_pair_adder #(.VEC_W(VW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .size_code(size_code), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // reference model: R1 R2 R3 R4
  function automatic logic [VW-1:0] ref_model(input logic [1:0] code,
                                              input logic [VW-1:0] a,
                                              input logic [VW-1:0] b);
    logic [VW-1:0] r;
    int w, per;
    w = 8 * (1 << code);
    per = 128 / w;
    r = '0;
    for (int s = 0; s < NS; s++) begin
      logic [255:0] cat;
      logic [127:0] seg;
      cat = {b[s*128 +: 128], a[s*128 +: 128]};
      seg = '0;
      for (int e = 0; e < per; e++) begin
        logic [63:0] x, y, m, t;
        m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        x = 64'(cat >> (2*e*w)) & m;
        y = 64'(cat >> ((2*e+1)*w)) & m;
        t = (x + y) & m;
        seg = seg | (128'(t) << (e*w));
      end
      r[s*128 +: 128] = seg;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: offer one operation and push the expected result
  task automatic send(input logic [1:0] code, input logic [VW-1:0] a,
                      input logic [VW-1:0] b, input int tag);
    @(negedge clk);
    in_valid  = 1'b1;
    size_code = code;
    src_a     = a;
    src_b     = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(ref_model(code, a, b));
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    // R6: valid the cycle after acceptance
    check(out_valid === 1'b1, "R6 valid after accept", VW'(out_valid), VW'(1));
  endtask

  // consumer back-pressure pattern
  int rcnt = 0;
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      rcnt++;
      out_ready = !((rcnt % 5) == 2 || (rcnt % 7) == 3);
    end
  end

  // monitor / scoreboard
  logic [VW-1:0] held;
  bit            was_held = 0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst) begin
        if (was_held) begin
          // R7: held result unchanged
          check(out_valid === 1'b1 && out_data === held, "R7 stall hold", out_data, held);
        end
        was_held = 0;
        if (out_valid && !out_ready) begin
          held = out_data;
          was_held = 1;
          // R7: no new acceptance while stalled
          check(in_ready === 1'b0, "R7 ready low in stall", VW'(in_ready), VW'(0));
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected result", out_data, '0);
          end else begin
            logic [VW-1:0] e;
            int t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            case (t)
              1: check(out_data === e, "R4 wrap all-ones", out_data, e);
              2: check(out_data === e, "R2 low half from src_a", out_data, e);
              3: check(out_data === e, "R3 high half from src_b", out_data, e);
              default: check(out_data === e, "R1 R5 random", out_data, e);
            endcase
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    size_code = 2'd0;
    src_a = '0;
    src_b = '0;
    repeat (3) @(posedge clk);
    #2;
    // R8: reset state
    check(out_valid === 1'b0, "R8 out_valid reset", VW'(out_valid), '0);
    check(out_data === '0, "R8 out_data reset", out_data, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int c = 0; c < 4; c++) begin
      // R4: all-ones gives 0xFE.. per element at every width
      send(2'(c), '1, '1, 1);
      // R2: src_b zero, upper halves must be zero
      send(2'(c), rnd_vec(), '0, 2);
      // R3: src_a zero, lower halves must be zero
      send(2'(c), '0, rnd_vec(), 3);
      for (int k = 0; k < 6; k++) send(2'(c), rnd_vec(), rnd_vec(), 0);
    end
    // back-to-back mixed widths
    for (int k = 0; k < 12; k++) send(2'(k % 4), rnd_vec(), rnd_vec(), 0);

    // R4: explicit 8-bit all-ones value, independent of the model
    send(2'd0, '1, '1, 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(out_data === {(VW/8){8'hFE}}, "R4 8-bit wrap literal", out_data,
          {(VW/8){8'hFE}});

    // R8: reset with a result pending clears it
    send(2'd3, rnd_vec(), rnd_vec(), 0);
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check(out_valid === 1'b0 && out_data === '0, "R8 reset mid-run", out_data, '0);
    @(negedge clk);
    rst = 1'b0;

    repeat (4) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule